// File: doc/BRIEF.md
# Threshold Sample FIFO with Status and Interrupt

This block buffers audio samples between a register-access side and a serial frame engine. One instance serves one direction. A parameter chooses the variant. In the receive variant the frame engine pushes samples and software pops them. In the transmit variant software pushes and the frame engine pops. The fill level can be read at all times. The level is compared with a programmable threshold to produce a level flag: "full" in the receive variant and "empty" in the transmit variant. The flag follows the threshold and not the physical occupancy.

Three error conditions are held in sticky status bits until software clears them by writing a one to the bit. The first is a sample lost on a push into a physically full receive FIFO. The second is a pop from an empty transmit FIFO. The third is a framing error reported by the frame engine. An interrupt enable mask is changed through two separate strobe ports, one that sets bits and one that clears them. The masked status drives a single registered interrupt line. A two-bit direction enable (bit 0 receive, bit 1 transmit) gates the instance. A disabled FIFO is flushed.

Top module: `smpl_thr_fifo`

## Requirements
- R1: `level` equals the number of stored samples. Samples leave in arrival order. `pop_data` shows the oldest sample in the same cycle whenever `level` is non-zero and shows zero when `level` is zero. After reset `level`, `status`, `ien_q`, `irq` and `thr_err` are all zero and `thr_q` is DEPTH/2.
- R2: Status bit 0 (value 0x01) is the receive level flag and is set while `level >= thr_q` in the receive variant. Status bit 1 (value 0x02) is the transmit level flag and is set while `level <= thr_q` in the transmit variant. The flag that does not belong to the variant reads 0.
- R3: A threshold write with `MIN_THR <= value <= DEPTH` is stored and sets `thr_err` to 0. A value above DEPTH is rejected and sets `thr_err` to 2'b01. A value below MIN_THR is rejected and sets `thr_err` to 2'b10. A rejected write leaves `thr_q` unchanged. `thr_err` updates on the edge of the write.
- R4: In the receive variant, a push while `level == DEPTH` and no pop in the same cycle drops the sample, leaves `level` at DEPTH and sets sticky status bit 2 (0x04).
- R5: In the transmit variant, a pop while `level == 0` returns zero on `pop_data` and sets sticky status bit 3 (0x08). A push in the same cycle is still stored.
- R6: A one on `frame_err` sets sticky status bit 4 (0x10).
- R7: A one in bit n of `stat_clr` clears sticky bit n on the next edge. An error event in the same cycle wins, and the bit stays set.
- R8: Each one in `ien_set` turns the matching bit of `ien_q` on, and each one in `ien_clr` turns it off. If both strobes hit the same bit in the same cycle, the clear wins.
- R9: `irq` is set one cycle after any bit is set in both `status` and `ien_q`, and it is low otherwise.
- R10: The receive variant is enabled by `dir_en[0]` and the transmit variant by `dir_en[1]`. While disabled, the FIFO flushes to level 0 on the next edge. Pushes are ignored, and pops return zero and raise no underrun.
- R11: A push and a pop in the same cycle on a non-empty FIFO both take effect and `level` is unchanged. On a physically full FIFO the push is accepted and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_en | input | 2 | Direction enables: bit 0 receive, bit 1 transmit |
| push | input | 1 | Store `push_data` this cycle |
| push_data | input | DW | Sample to store |
| pop | input | 1 | Remove the oldest sample this cycle |
| pop_data | output | DW | Oldest sample, or zero when empty or disabled |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | LW | Threshold value to write |
| thr_q | output | LW | Current threshold |
| thr_err | output | 2 | Result of last threshold write: bit 0 too high, bit 1 too low |
| ien_set | input | 5 | Interrupt enable set strobes |
| ien_clr | input | 5 | Interrupt enable clear strobes |
| ien_q | output | 5 | Current interrupt enable mask |
| stat_clr | input | 5 | Write-one-to-clear strobes for sticky status |
| frame_err | input | 1 | Framing error pulse from the frame engine |
| level | output | LW | Current fill level |
| status | output | 5 | Status: level flags in bits 1:0, sticky errors in bits 4:2 |
| irq | output | 1 | Registered interrupt request |

## Verification
Two things can happen in the same cycle here: a push and a pop. This matters at both physical limits. The bench fills a receive FIFO to DEPTH and then pushes and pops together. It expects the level to stay at DEPTH, the popped value to be the old head, and the overrun bit to stay clear. At the empty limit, the bench pops and pushes together on an empty transmit FIFO. It expects zero on `pop_data`, the underrun bit set, and a level of one. The same concern applies to a sticky error event arriving in the same cycle as its clear strobe. The bench provokes this with an overrun push beside a clear of bit 2 and with a framing pulse beside a clear of bit 4, and expects the bit to stay set in both cases.

// File: rtl/smpl_fifo_pkg.sv
// Package: shared status bit positions and threshold result codes for the
// threshold sample FIFO. Assumes a five-bit status word.
package smpl_fifo_pkg;
    localparam int ST_W        = 5;
    localparam int ST_RX_LVL   = 0;   // receive level flag, 0x01
    localparam int ST_TX_LVL   = 1;   // transmit level flag, 0x02
    localparam int ST_OVR      = 2;   // receive overrun, 0x04
    localparam int ST_UND      = 3;   // transmit underrun, 0x08
    localparam int ST_FRM      = 4;   // framing error, 0x10

    typedef enum logic [1:0] {
        THR_OK  = 2'b00,
        THR_HI  = 2'b01,
        THR_LO  = 2'b10
    } thr_res_e;
endpackage

// File: rtl/sf_store.sv
// Sample storage: circular buffer in flops with a fill counter.
// Produces the oldest sample combinationally and one-cycle event pulses
// for a push that found no room and a pop that found nothing.
// Assumes DEPTH >= 1; a disabled store flushes and ignores requests.
module sf_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int LW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [LW-1:0] level,
    output logic          ovr_evt,
    output logic          udf_evt
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] level_q;
    logic          is_empty, is_full, pop_ok, push_ok;

    // Pointer advance with wrap at DEPTH-1 (any depth, not only powers of two).
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign is_empty = (level_q == '0);
    assign is_full  = (level_q == LW'(DEPTH));
    assign pop_ok   = en && pop && !is_empty;
    assign push_ok  = en && push && (!is_full || pop_ok);
    assign ovr_evt  = en && push && !push_ok;
    assign udf_evt  = en && pop && is_empty;
    assign pop_data = (en && !is_empty) ? mem[rd_ptr] : '0;
    assign level    = level_q;

    // Sample write into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointer and fill-level update; flush while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_q <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LW'(DEPTH));
    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> level_q == '0);
    p_drop_keeps_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en && push && !pop && is_full |=> level_q == LW'(DEPTH));
    p_pushpop_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        en && push && pop && !is_empty |=> level_q == $past(level_q));
endmodule

// File: rtl/sf_thresh.sv
// Threshold register with range check. A write inside [MIN_THR, DEPTH]
// is stored; any other write is refused and the reason is latched.
// Assumes MIN_THR <= DEPTH and that LW can hold DEPTH.
module sf_thresh
    import smpl_fifo_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int MIN_THR = 1,
    parameter int LW      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [LW-1:0] wdata,
    output logic [LW-1:0] thr,
    output logic [1:0]    err
);
    localparam int THR_RST = (DEPTH / 2 < MIN_THR) ? MIN_THR : DEPTH / 2;

    logic too_hi, too_lo;
    assign too_hi = wdata > LW'(DEPTH);
    assign too_lo = wdata < LW'(MIN_THR);

    // Threshold store and write-result latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= LW'(THR_RST);
            err <= THR_OK;
        end else if (wr) begin
            if (too_hi)      err <= THR_HI;
            else if (too_lo) err <= THR_LO;
            else begin
                err <= THR_OK;
                thr <= wdata;
            end
        end
    end

    p_reject_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr && (too_hi || too_lo) |=> thr == $past(thr));
    p_thr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        thr >= LW'(MIN_THR) && thr <= LW'(DEPTH));
    p_err_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err));
endmodule

// File: rtl/sf_status.sv
// Status word, interrupt enable mask and registered interrupt.
// Level flags pass through; error events latch until a one is written
// to the matching clear strobe, with a same-cycle event taking priority.
// Assumes the two level flag inputs are already variant-gated.
module sf_status
    import smpl_fifo_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_lvl,
    input  logic            tx_lvl,
    input  logic            ovr_evt,
    input  logic            udf_evt,
    input  logic            frm_evt,
    input  logic [ST_W-1:0] clr,
    input  logic [ST_W-1:0] ien_set,
    input  logic [ST_W-1:0] ien_clr,
    output logic [ST_W-1:0] status,
    output logic [ST_W-1:0] ien,
    output logic            irq
);
    logic [ST_W-1:0] sticky_q, ev, lvl;

    // Event vector in status-bit positions; level flags never latch.
    always_comb begin
        ev         = '0;
        ev[ST_OVR] = ovr_evt;
        ev[ST_UND] = udf_evt;
        ev[ST_FRM] = frm_evt;
        lvl            = '0;
        lvl[ST_RX_LVL] = rx_lvl;
        lvl[ST_TX_LVL] = tx_lvl;
    end

    assign status = sticky_q | lvl;

    // Sticky error bits: clear by strobe, set by event, event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= (sticky_q & ~clr) | ev;
    end

    // Interrupt enable mask with separate set and clear strobes, clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n) ien <= '0;
        else        ien <= (ien | ien_set) & ~ien_clr;
    end

    // Registered interrupt from the masked status.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(status & ien);
    end

    p_ovr_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> status[ST_OVR]);
    p_und_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        udf_evt |=> status[ST_UND]);
    p_frm_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_evt |=> status[ST_FRM]);
    p_clear_works_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr[ST_OVR] && !ovr_evt |=> !status[ST_OVR]);
    p_sticky_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_FRM] && !clr[ST_FRM] |=> status[ST_FRM]);
    p_ien_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ien_clr != '0 |=> (ien & $past(ien_clr)) == '0);
    p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ien) != '0);
endmodule

// File: rtl/smpl_thr_fifo.sv
// Top: one-direction threshold sample FIFO. IS_RX selects the receive
// variant (level flag on reaching threshold, overrun on lost push) or the
// transmit variant (level flag on falling to threshold, underrun on empty
// pop). Assumes single clock, synchronous active-low reset.
module smpl_thr_fifo
    import smpl_fifo_pkg::*;
#(
    parameter  int IS_RX   = 1,
    parameter  int DW      = 16,
    parameter  int DEPTH   = 16,
    parameter  int MIN_THR = 1,
    localparam int LW      = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      dir_en,
    input  logic            push,
    input  logic [DW-1:0]   push_data,
    input  logic            pop,
    output logic [DW-1:0]   pop_data,
    input  logic            thr_we,
    input  logic [LW-1:0]   thr_wdata,
    output logic [LW-1:0]   thr_q,
    output logic [1:0]      thr_err,
    input  logic [ST_W-1:0] ien_set,
    input  logic [ST_W-1:0] ien_clr,
    output logic [ST_W-1:0] ien_q,
    input  logic [ST_W-1:0] stat_clr,
    input  logic            frame_err,
    output logic [LW-1:0]   level,
    output logic [ST_W-1:0] status,
    output logic            irq
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic fifo_en, ovr_raw, udf_raw, ovr_use, udf_use, rx_flag, tx_flag;

    // Direction enable, overflow/underflow and level flags per variant.
    generate
        if (IS_RX != 0) begin : g_rx
            assign fifo_en = dir_en[0];
            assign ovr_use = ovr_raw;
            assign udf_use = 1'b0;
            assign rx_flag = level >= thr_q;
            assign tx_flag = 1'b0;
        end else begin : g_tx
            assign fifo_en = dir_en[1];
            assign ovr_use = 1'b0;
            assign udf_use = udf_raw;
            assign rx_flag = 1'b0;
            assign tx_flag = level <= thr_q;
        end
    endgenerate

    // Keep the unused direction bit and event referenced for lint.
    logic unused_ok;
    assign unused_ok = ^{dir_en, ovr_raw, udf_raw};

    sf_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .LW(LW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (fifo_en),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .level     (level),
        .ovr_evt   (ovr_raw),
        .udf_evt   (udf_raw)
    );

    sf_thresh #(.DEPTH(DEPTH), .MIN_THR(MIN_THR), .LW(LW)) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (thr_we),
        .wdata (thr_wdata),
        .thr   (thr_q),
        .err   (thr_err)
    );

    sf_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_lvl  (rx_flag),
        .tx_lvl  (tx_flag),
        .ovr_evt (ovr_use),
        .udf_evt (udf_use),
        .frm_evt (frame_err),
        .clr     (stat_clr),
        .ien_set (ien_set),
        .ien_clr (ien_clr),
        .status  (status),
        .ien     (ien_q),
        .irq     (irq)
    );

    p_wrong_flag_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_RX != 0) ? !status[ST_TX_LVL] : !status[ST_RX_LVL]);
    p_empty_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level == '0 |-> pop_data == '0);
endmodule

// File: tb/sim_smpl_thr_fifo.sv
module sim_smpl_thr_fifo;
    localparam int DW = 16;
    localparam int DEPTH = 8;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] dir_en = 2'b11;
    always #5 clk = ~clk;

    // receive instance signals (u0)
    logic a_push = 0, a_pop = 0, a_thr_we = 0, a_frm = 0;
    logic [DW-1:0] a_pd = '0, a_qd;
    logic [LW-1:0] a_thr_wd = '0, a_thr, a_lvl;
    logic [1:0] a_terr;
    logic [4:0] a_iset = '0, a_iclr = '0, a_ien, a_sclr = '0, a_st;
    logic a_irq;
    // transmit instance signals (u1)
    logic b_push = 0, b_pop = 0, b_thr_we = 0, b_frm = 0;
    logic [DW-1:0] b_pd = '0, b_qd;
    logic [LW-1:0] b_thr_wd = '0, b_thr, b_lvl;
    logic [1:0] b_terr;
    logic [4:0] b_iset = '0, b_iclr = '0, b_ien, b_sclr = '0, b_st;
    logic b_irq;

    smpl_thr_fifo #(.IS_RX(1), .DW(DW), .DEPTH(DEPTH), .MIN_THR(1)) u0 (
        .clk(clk), .rst_n(rst_n), .dir_en(dir_en), .push(a_push), .push_data(a_pd),
        .pop(a_pop), .pop_data(a_qd), .thr_we(a_thr_we), .thr_wdata(a_thr_wd),
        .thr_q(a_thr), .thr_err(a_terr), .ien_set(a_iset), .ien_clr(a_iclr),
        .ien_q(a_ien), .stat_clr(a_sclr), .frame_err(a_frm), .level(a_lvl),
        .status(a_st), .irq(a_irq));

    smpl_thr_fifo #(.IS_RX(0), .DW(DW), .DEPTH(DEPTH), .MIN_THR(1)) u1 (
        .clk(clk), .rst_n(rst_n), .dir_en(dir_en), .push(b_push), .push_data(b_pd),
        .pop(b_pop), .pop_data(b_qd), .thr_we(b_thr_we), .thr_wdata(b_thr_wd),
        .thr_q(b_thr), .thr_err(b_terr), .ien_set(b_iset), .ien_clr(b_iclr),
        .ien_q(b_ien), .stat_clr(b_sclr), .frame_err(b_frm), .level(b_lvl),
        .status(b_st), .irq(b_irq));

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // threshold vectors: [11:8] written value, [7:4] expected error, [3:0] expected threshold
    localparam logic [11:0] THR_VEC [8] = '{
        {4'd0,  4'd2, 4'd4}, {4'd9, 4'd1, 4'd4}, {4'd8, 4'd0, 4'd8}, {4'd1, 4'd0, 4'd1},
        {4'd15, 4'd1, 4'd1}, {4'd3, 4'd0, 4'd3}, {4'd0, 4'd2, 4'd3}, {4'd5, 4'd0, 4'd5}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: inputs were set after a falling edge; return after the next falling edge
    // with all strobes released.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        a_push = 0; a_pop = 0; a_thr_we = 0; a_frm = 0; a_iset = '0; a_iclr = '0; a_sclr = '0;
        b_push = 0; b_pop = 0; b_thr_we = 0; b_frm = 0; b_iset = '0; b_iclr = '0; b_sclr = '0;
    endtask

    task automatic a_put(input int v);
        a_push = 1; a_pd = DW'(v); step();
    endtask

    task automatic b_put(input int v);
        b_push = 1; b_pd = DW'(v); step();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1", "reset level", int'(a_lvl), 0);
        chk("R1", "reset status rx", int'(a_st), 0);
        chk("R1", "reset ien", int'(a_ien), 0);
        chk("R1", "reset irq", int'(a_irq), 0);
        chk("R1", "reset thr", int'(a_thr), 4);
        chk("R1", "reset thr_err", int'(a_terr), 0);
        chk("R2", "reset status tx (empty flag)", int'(b_st), 2);

        // R3 threshold table
        for (int i = 0; i < 8; i++) begin
            a_thr_we = 1; a_thr_wd = THR_VEC[i][11:8];
            step();
            chk("R3", "thr_err", int'(a_terr), int'(THR_VEC[i][7:4]));
            chk("R3", "thr_q", int'(a_thr), int'(THR_VEC[i][3:0]));
        end
        a_thr_we = 1; a_thr_wd = 4'd3; step();

        // R2 receive level flag at threshold 3
        a_put(1); a_put(2);
        chk("R2", "rx below threshold", int'(a_st), 0);
        a_put(3);
        chk("R2", "rx at threshold", int'(a_st), 1);
        chk("R1", "level 3", int'(a_lvl), 3);
        for (int v = 4; v <= 8; v++) a_put(v);
        chk("R1", "level full", int'(a_lvl), 8);
        // R4 overrun
        a_put(9);
        chk("R4", "level after drop", int'(a_lvl), 8);
        chk("R4", "status overrun", int'(a_st), 5);
        // R1 ordering
        chk("R1", "head value", int'(a_qd), 1);
        a_pop = 1; step();
        chk("R1", "second head", int'(a_qd), 2);
        a_pop = 1; step();
        chk("R1", "level after pops", int'(a_lvl), 6);
        // R7 clear
        a_sclr = 5'h04; step();
        chk("R7", "overrun cleared", int'(a_st), 1);
        a_put(10); a_put(11);
        chk("R11", "head before pushpop", int'(a_qd), 3);
        // R11 push+pop on full
        a_push = 1; a_pd = 16'd12; a_pop = 1; step();
        chk("R11", "level kept", int'(a_lvl), 8);
        chk("R11", "no overrun", int'(a_st), 1);
        chk("R11", "new head", int'(a_qd), 4);
        // R9 irq lag, R8 mask
        a_iset = 5'h01; step();
        chk("R8", "ien set", int'(a_ien), 1);
        chk("R9", "irq lags mask", int'(a_irq), 0);
        step();
        chk("R9", "irq raised", int'(a_irq), 1);
        a_iset = 5'h06; a_iclr = 5'h02; step();
        chk("R8", "clear wins", int'(a_ien), 5);
        // R7 event wins over clear
        a_push = 1; a_pd = 16'd13; a_sclr = 5'h04; step();
        chk("R7", "event beats clear", int'(a_st), 5);
        chk("R4", "level after second drop", int'(a_lvl), 8);
        a_iclr = 5'h05; step();
        chk("R8", "ien cleared", int'(a_ien), 0);
        step();
        chk("R9", "irq dropped", int'(a_irq), 0);
        // R6 framing, R7 event beats clear
        a_sclr = 5'h04; step();
        a_frm = 1; step();
        chk("R6", "framing set", int'(a_st), 5'h11);
        a_frm = 1; a_sclr = 5'h10; step();
        chk("R7", "framing event beats clear", int'(a_st), 5'h11);
        a_sclr = 5'h10; step();
        chk("R7", "framing cleared", int'(a_st), 1);
        // R1 drain order
        begin
            int exp_q [8] = '{4, 5, 6, 7, 8, 10, 11, 12};
            for (int i = 0; i < 8; i++) begin
                chk("R1", "drain value", int'(a_qd), exp_q[i]);
                a_pop = 1; step();
            end
        end
        chk("R1", "drained level", int'(a_lvl), 0);
        chk("R1", "empty reads zero", int'(a_qd), 0);
        a_pop = 1; step();
        chk("R2", "rx empty pop no status", int'(a_st), 0);
        // R10 disable
        a_put(20); a_put(21);
        dir_en = 2'b10; step();
        chk("R10", "rx flushed", int'(a_lvl), 0);
        a_put(22);
        chk("R10", "rx push ignored", int'(a_lvl), 0);
        chk("R10", "rx disabled pop data", int'(a_qd), 0);
        dir_en = 2'b11; step();

        // Transmit instance, threshold 4
        for (int v = 1; v <= 5; v++) b_put(v);
        chk("R2", "tx above threshold", int'(b_st), 0);
        chk("R1", "tx head", int'(b_qd), 1);
        b_pop = 1; step();
        chk("R2", "tx at threshold", int'(b_st), 2);
        for (int v = 2; v <= 5; v++) begin
            chk("R1", "tx order", int'(b_qd), v);
            b_pop = 1; step();
        end
        chk("R5", "tx empty pop data", int'(b_qd), 0);
        b_pop = 1; step();
        chk("R5", "underrun set", int'(b_st), 5'h0A);
        chk("R5", "level stays 0", int'(b_lvl), 0);
        b_sclr = 5'h08; step();
        chk("R7", "underrun cleared", int'(b_st), 2);
        b_pop = 1; b_push = 1; b_pd = 16'd7; step();
        chk("R5", "pushpop on empty underrun", int'(b_st), 5'h0A);
        chk("R5", "pushpop on empty stored", int'(b_lvl), 1);
        chk("R5", "stored value", int'(b_qd), 7);
        b_sclr = 5'h08; dir_en = 2'b01; step();
        chk("R10", "tx flushed", int'(b_lvl), 0);
        b_pop = 1; step();
        chk("R10", "tx disabled pop no underrun", int'(b_st), 2);
        chk("R10", "rx still enabled level", int'(a_lvl), 0);

        done = 1;
        summary();
    end
endmodule